// File: doc/BRIEF.md
# Branch Target Buffer with Static Steering Modes

This block turns a branch direction into the next fetch address. A set-associative table holds branches that recently resolved taken, each with its target. On every cycle the front end presents a branch address, a direction from an external predictor, and a mode that can override that direction with a fixed policy. The block returns the address to fetch next. It also returns a flag for the case where the branch is predicted taken but the table holds no target for it.

Lookup is combinational, so the answer is ready in the same cycle the address is presented. A resolve port writes the real target when a branch executes and turns out taken. Not-taken resolves are ignored. Within a set, victims are picked in least-recently-used order, and a taken resolve that hits refreshes both the target and the recency.

Top module: `branch_target_buffer`

## Requirements
- R1: Reset invalidates every entry. After reset, every lookup misses, so any taken prediction reports target-unknown until a taken resolve is written.
- R2: When the final direction is not taken, `pred_pc` equals `lk_pc + INST_BYTES` (default 4), `pred_taken` is 0 and `pred_tgt_unknown` is 0.
- R3: When the final direction is taken and the branch address matches a valid entry, `pred_pc` is that entry's stored target and `pred_tgt_unknown` is 0.
- R4: When the final direction is taken and no entry matches, `pred_taken` is 1, `pred_tgt_unknown` is 1 and `pred_pc` is the fall-through address.
- R5: A resolve with `upd_taken` = 0 writes nothing. A later lookup of that branch behaves exactly as it did before the resolve.
- R6: A taken resolve for a branch already held overwrites the stored target in place. The new target is returned from the next cycle on.
- R7: The set index is `pc[8:2]` with the defaults (bits `OFF_W+IDX_W-1 : OFF_W`). A set has 4 ways. A miss fills an invalid way first, otherwise the least recently written or refreshed way. Five branches in one set evict the one touched longest ago.
- R8: `lk_mode` selects the final direction. The encodings are: 0 follows `lk_dyn_taken`; 1 is always taken; 2 is always not taken; 3 is taken exactly when `lk_pc` > `lk_dir_target` as unsigned numbers. Equal addresses count as not taken.
- R9: A resolve takes effect at the clock edge. A lookup in the same cycle sees the contents from before the write, and a lookup in the next cycle sees the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | ADDR_W | Address of the branch being looked up |
| lk_dir_target | input | ADDR_W | Decoded target, used only for the backward/forward comparison in mode 3 |
| lk_dyn_taken | input | 1 | Direction from the external predictor |
| lk_mode | input | 2 | Direction source: 0 dynamic, 1 taken, 2 not taken, 3 backward-taken |
| pred_pc | output | ADDR_W | Predicted next fetch address |
| pred_taken | output | 1 | Final predicted direction |
| pred_tgt_unknown | output | 1 | Taken, but no stored target |
| upd_valid | input | 1 | Resolve strobe |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | ADDR_W | Actual target of the resolved branch |

## Verification
A lookup and a resolve can hit the same set, or the same branch, in one cycle. The bench provokes this by driving the resolve of a branch that is not yet held together with a lookup of that branch. It expects target-unknown in that cycle and the new target one cycle later. The LRU test also interleaves refresh writes with fills of the same set, and judges the result by which of five aliasing branches still hit.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef enum logic [1:0] {
        STEER_DYNAMIC  = 2'd0,
        STEER_TAKEN    = 2'd1,
        STEER_NOT_TAKEN = 2'd2,
        STEER_BACKWARD = 2'd3
    } steer_mode_e;

    // Final direction chosen by the steering mode.
    function automatic logic steer_dir(steer_mode_e mode, logic dyn_taken,
                                       logic is_backward);
        logic d;
        case (mode)
            STEER_DYNAMIC:   d = dyn_taken;
            STEER_TAKEN:     d = 1'b1;
            STEER_NOT_TAKEN: d = 1'b0;
            default:         d = is_backward;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/btb_way_bank.sv
module btb_way_bank #(
    parameter int SETS   = 128,
    parameter int TAG_W  = 25,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst,
    // lookup read port
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_hit,
    output logic [ADDR_W-1:0] rd_target,
    // resolve probe port
    input  logic [IDX_W-1:0]  pr_idx,
    input  logic [TAG_W-1:0]  pr_tag,
    output logic              pr_hit,
    output logic              pr_valid,
    // write port
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_target
);
    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q [SETS];
    logic [ADDR_W-1:0] tgt_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_target;
        end
    end

    assign rd_hit    = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    assign rd_target = tgt_q[rd_idx];
    assign pr_valid  = valid_q[pr_idx];
    assign pr_hit    = valid_q[pr_idx] && (tag_q[pr_idx] == pr_tag);

endmodule

// File: rtl/btb_lru.sv
module btb_lru #(
    parameter int SETS = 128,
    parameter int WAYS = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [IDX_W-1:0] query_idx,
    output logic [WAY_W-1:0] oldest_way
);
    // Per-set age rank: 0 = most recent, WAYS-1 = oldest. Always a permutation.
    logic [WAY_W-1:0] age_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way) begin
                    age_q[touch_idx][w] <= '0;
                end else if (age_q[touch_idx][w] < age_q[touch_idx][touch_way]) begin
                    age_q[touch_idx][w] <= age_q[touch_idx][w] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        oldest_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (age_q[query_idx][w] == WAY_W'(WAYS - 1)) begin
                oldest_way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/btb_steer.sv
module btb_steer
    import btb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int INST_BYTES = 4
) (
    input  steer_mode_e       mode,
    input  logic              dyn_taken,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] dir_target,
    input  logic              hit,
    input  logic [ADDR_W-1:0] hit_target,
    output logic [ADDR_W-1:0] next_pc,
    output logic              taken,
    output logic              tgt_unknown
);
    logic [ADDR_W-1:0] fall_through;
    logic              is_backward;

    assign fall_through = pc + ADDR_W'(INST_BYTES);
    assign is_backward  = pc > dir_target;

    always_comb begin
        taken       = steer_dir(mode, dyn_taken, is_backward);
        tgt_unknown = taken && !hit;
        next_pc     = (taken && hit) ? hit_target : fall_through;
    end

endmodule

// File: rtl/branch_target_buffer.sv
module branch_target_buffer
    import btb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ENTRIES    = 512,
    parameter int WAYS       = 4,
    parameter int INST_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lk_pc,
    input  logic [ADDR_W-1:0] lk_dir_target,
    input  logic              lk_dyn_taken,
    input  logic [1:0]        lk_mode,
    output logic [ADDR_W-1:0] pred_pc,
    output logic              pred_taken,
    output logic              pred_tgt_unknown,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target
);
    localparam int SETS  = ENTRIES / WAYS;
    localparam int IDX_W = $clog2(SETS);
    localparam int OFF_W = $clog2(INST_BYTES);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int WAY_W = $clog2(WAYS);

    // Tag holds every address bit outside the index field.
    function automatic logic [TAG_W-1:0] tag_of(logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:OFF_W+IDX_W], a[OFF_W-1:0]};
    endfunction

    logic [IDX_W-1:0]  lk_idx, up_idx;
    logic [TAG_W-1:0]  lk_tag, up_tag;
    logic [WAYS-1:0]   way_hit, way_pr_hit, way_pr_valid, way_wr;
    logic [ADDR_W-1:0] way_tgt [WAYS];
    logic              lk_hit;
    logic [ADDR_W-1:0] lk_tgt;
    logic [WAY_W-1:0]  oldest_way, sel_way;
    logic              do_write;

    assign lk_idx   = lk_pc[OFF_W +: IDX_W];
    assign lk_tag   = tag_of(lk_pc);
    assign up_idx   = upd_pc[OFF_W +: IDX_W];
    assign up_tag   = tag_of(upd_pc);
    assign do_write = upd_valid && upd_taken;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign way_wr[w] = do_write && (sel_way == WAY_W'(w));
        btb_way_bank #(
            .SETS(SETS), .TAG_W(TAG_W), .ADDR_W(ADDR_W)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .rd_idx   (lk_idx),
            .rd_tag   (lk_tag),
            .rd_hit   (way_hit[w]),
            .rd_target(way_tgt[w]),
            .pr_idx   (up_idx),
            .pr_tag   (up_tag),
            .pr_hit   (way_pr_hit[w]),
            .pr_valid (way_pr_valid[w]),
            .wr_en    (way_wr[w]),
            .wr_idx   (up_idx),
            .wr_tag   (up_tag),
            .wr_target(upd_target)
        );
    end

    // At most one way can match: allocation happens only on a miss.
    always_comb begin
        lk_hit = 1'b0;
        lk_tgt = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_hit[w]) begin
                lk_hit = 1'b1;
                lk_tgt = way_tgt[w];
            end
        end
    end

    // Write way: matching way, else first invalid way, else LRU victim.
    always_comb begin
        logic found_hit, found_free;
        sel_way    = oldest_way;
        found_hit  = 1'b0;
        found_free = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found_hit && way_pr_hit[w]) begin
                sel_way   = WAY_W'(w);
                found_hit = 1'b1;
            end
        end
        if (!found_hit) begin
            for (int w = 0; w < WAYS; w++) begin
                if (!found_free && !way_pr_valid[w]) begin
                    sel_way    = WAY_W'(w);
                    found_free = 1'b1;
                end
            end
        end
    end

    btb_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk       (clk),
        .rst       (rst),
        .touch_en  (do_write),
        .touch_idx (up_idx),
        .touch_way (sel_way),
        .query_idx (up_idx),
        .oldest_way(oldest_way)
    );

    btb_steer #(.ADDR_W(ADDR_W), .INST_BYTES(INST_BYTES)) u_steer (
        .mode       (steer_mode_e'(lk_mode)),
        .dyn_taken  (lk_dyn_taken),
        .pc         (lk_pc),
        .dir_target (lk_dir_target),
        .hit        (lk_hit),
        .hit_target (lk_tgt),
        .next_pc    (pred_pc),
        .taken      (pred_taken),
        .tgt_unknown(pred_tgt_unknown)
    );

endmodule

// File: rtl/branch_target_buffer_chk.sv
module branch_target_buffer_chk #(
    parameter int ADDR_W     = 32,
    parameter int INST_BYTES = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] lk_pc,
    input logic [ADDR_W-1:0] lk_dir_target,
    input logic              lk_dyn_taken,
    input logic [1:0]        lk_mode,
    input logic [ADDR_W-1:0] pred_pc,
    input logic              pred_taken,
    input logic              pred_tgt_unknown,
    input logic              upd_valid,
    input logic [ADDR_W-1:0] upd_pc,
    input logic              upd_taken,
    input logic [ADDR_W-1:0] upd_target
);
    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) && pred_taken |-> pred_tgt_unknown);

    // R2
    fall_through_chk: assert property (@(posedge clk) disable iff (rst)
        !pred_taken |-> (pred_pc == lk_pc + ADDR_W'(INST_BYTES)) && !pred_tgt_unknown);

    // R4
    unknown_fallback_chk: assert property (@(posedge clk) disable iff (rst)
        pred_tgt_unknown |-> pred_taken && (pred_pc == lk_pc + ADDR_W'(INST_BYTES)));

    // R8
    mode_taken_chk: assert property (@(posedge clk) disable iff (rst)
        lk_mode == 2'd1 |-> pred_taken);

    // R8
    mode_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
        lk_mode == 2'd2 |-> !pred_taken);

    // R8
    mode_backward_chk: assert property (@(posedge clk) disable iff (rst)
        lk_mode == 2'd3 |-> pred_taken == (lk_pc > lk_dir_target));

    // R9
    write_visible_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(upd_valid && upd_taken) && lk_mode == 2'd1
        && lk_pc == $past(upd_pc)
        |-> !pred_tgt_unknown && pred_pc == $past(upd_target));

endmodule

bind branch_target_buffer branch_target_buffer_chk #(
    .ADDR_W(ADDR_W), .INST_BYTES(INST_BYTES)
) u_chk (.*);

// File: tb/branch_target_buffer_tb.sv
module branch_target_buffer_tb;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] lk_pc = '0, lk_dir_target = '0, upd_pc = '0, upd_target = '0;
    logic          lk_dyn_taken = 1'b0, upd_valid = 1'b0, upd_taken = 1'b0;
    logic [1:0]    lk_mode = 2'd0;
    logic [AW-1:0] pred_pc;
    logic          pred_taken, pred_tgt_unknown;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    branch_target_buffer u_dut (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_dir_target(lk_dir_target),
        .lk_dyn_taken(lk_dyn_taken), .lk_mode(lk_mode), .pred_pc(pred_pc),
        .pred_taken(pred_taken), .pred_tgt_unknown(pred_tgt_unknown),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target)
    );

    task automatic chk(bit ok, string req, logic [AW-1:0] act, logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present a lookup mid-cycle and let the combinational outputs settle.
    task automatic look(logic [AW-1:0] pc, logic [1:0] mode, logic dyn,
                        logic [AW-1:0] dtgt);
        @(negedge clk);
        lk_pc = pc; lk_mode = mode; lk_dyn_taken = dyn; lk_dir_target = dtgt;
        #1;
    endtask

    task automatic resolve(logic [AW-1:0] pc, logic tk, logic [AW-1:0] tgt);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tgt;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    // Expect a hit in always-taken mode.
    task automatic expect_hit(logic [AW-1:0] pc, logic [AW-1:0] tgt, string req);
        look(pc, 2'd1, 1'b0, '0);
        chk(!pred_tgt_unknown && pred_pc == tgt, req, pred_pc, tgt);
    endtask

    task automatic expect_miss(logic [AW-1:0] pc, string req);
        look(pc, 2'd1, 1'b0, '0);
        chk(pred_tgt_unknown && pred_taken && pred_pc == pc + 4, req,
            {pred_pc[AW-2:0], pred_tgt_unknown}, {pc[AW-2:0] + 31'd4, 1'b1});
    endtask

    task automatic t_reset;
        expect_miss(32'h0000_1000, "R1 empty after reset");
        look(32'h0000_2000, 2'd0, 1'b1, '0);
        chk(pred_tgt_unknown == 1'b1, "R1 dynamic taken after reset", AW'(pred_tgt_unknown), 1);
    endtask

    task automatic t_not_taken;
        look(32'h0000_1230, 2'd0, 1'b0, '0);
        chk(!pred_taken && !pred_tgt_unknown && pred_pc == 32'h0000_1234,
            "R2 dynamic not taken", pred_pc, 32'h0000_1234);
    endtask

    task automatic t_hit_refresh;
        resolve(32'h0000_4000, 1'b1, 32'h0000_8888);
        look(32'h0000_4000, 2'd0, 1'b1, '0);
        chk(pred_taken && !pred_tgt_unknown && pred_pc == 32'h0000_8888,
            "R3 dynamic taken hit", pred_pc, 32'h0000_8888);
        look(32'h0000_4000, 2'd0, 1'b0, '0);
        chk(pred_pc == 32'h0000_4004, "R2 held branch predicted not taken", pred_pc, 32'h0000_4004);
        resolve(32'h0000_4000, 1'b1, 32'h0000_9990);
        expect_hit(32'h0000_4000, 32'h0000_9990, "R6 target refreshed");
    endtask

    task automatic t_not_taken_resolve;
        resolve(32'h0000_5000, 1'b0, 32'h0000_7770);
        expect_miss(32'h0000_5000, "R5 not-taken resolve not stored");
        resolve(32'h0000_4000, 1'b0, 32'h0000_1110);
        expect_hit(32'h0000_4000, 32'h0000_9990, "R5 not-taken resolve keeps entry");
    endtask

    task automatic t_lru;
        // Set index 5 (pc bits 8:2); stride 0x200 aliases into the same set.
        for (int i = 0; i < 4; i++)
            resolve(32'h0000_1014 + 32'(i) * 32'h200, 1'b1, 32'h0000_A000 + 32'(i) * 16);
        for (int i = 0; i < 4; i++)
            expect_hit(32'h0000_1014 + 32'(i) * 32'h200, 32'h0000_A000 + 32'(i) * 16,
                       "R7 four ways fill one set");
        resolve(32'h0000_1014, 1'b1, 32'h0000_A000);   // refresh oldest
        resolve(32'h0000_1814, 1'b1, 32'h0000_A040);   // fifth alias
        expect_miss(32'h0000_1214, "R7 LRU victim evicted");
        expect_hit(32'h0000_1014, 32'h0000_A000, "R7 refreshed entry kept");
        expect_hit(32'h0000_1414, 32'h0000_A020, "R7 way kept");
        expect_hit(32'h0000_1614, 32'h0000_A030, "R7 way kept");
        expect_hit(32'h0000_1814, 32'h0000_A040, "R7 new entry present");
        expect_miss(32'h0000_1018, "R7 neighbour set unaffected");
    endtask

    task automatic t_modes;
        look(32'h0000_4000, 2'd2, 1'b1, '0);
        chk(!pred_taken && pred_pc == 32'h0000_4004, "R8 mode 2 not taken", pred_pc, 32'h0000_4004);
        look(32'h0000_4000, 2'd1, 1'b0, '0);
        chk(pred_taken && pred_pc == 32'h0000_9990, "R8 mode 1 taken", pred_pc, 32'h0000_9990);
        look(32'h0000_4000, 2'd3, 1'b0, 32'h0000_3F00);
        chk(pred_taken && pred_pc == 32'h0000_9990, "R8 backward taken", pred_pc, 32'h0000_9990);
        look(32'h0000_4000, 2'd3, 1'b1, 32'h0000_4100);
        chk(!pred_taken && pred_pc == 32'h0000_4004, "R8 forward not taken", pred_pc, 32'h0000_4004);
        look(32'h0000_4000, 2'd3, 1'b1, 32'h0000_4000);
        chk(!pred_taken, "R8 equal address not taken", AW'(pred_taken), 0);
        look(32'h0000_6000, 2'd3, 1'b0, 32'h0000_0100);
        chk(pred_taken && pred_tgt_unknown && pred_pc == 32'h0000_6004,
            "R4 backward taken miss", pred_pc, 32'h0000_6004);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = 32'h0000_3000; upd_taken = 1'b1; upd_target = 32'h0000_0C00;
        lk_pc = 32'h0000_3000; lk_mode = 2'd1; lk_dyn_taken = 1'b0;
        #1;
        chk(pred_tgt_unknown && pred_pc == 32'h0000_3004, "R9 same-cycle sees old state",
            pred_pc, 32'h0000_3004);
        @(negedge clk);
        upd_valid = 1'b0;
        #1;
        chk(!pred_tgt_unknown && pred_pc == 32'h0000_0C00, "R9 visible next cycle",
            pred_pc, 32'h0000_0C00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_not_taken();
        t_hit_refresh();
        t_not_taken_resolve();
        t_lru();
        t_modes();
        t_same_cycle();
        // Reset again and confirm contents are gone.
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        expect_miss(32'h0000_4000, "R1 entry cleared by reset");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule